// File: doc/BRIEF.md
# Saturating Fractional Multiply-Accumulate Unit

This unit does the fixed-point arithmetic at the core of speech-codec style signal processing. Its inputs are two signed Q15 operands, a signed Q31 accumulator value and a 3-bit operation code. It returns one registered 32-bit result per accepted input.

The operations are:
- a doubled fractional product;
- multiply-add and multiply-subtract against the accumulator;
- rounding of a 32-bit value down to 16 bits, alone or after an accumulate step;
- a 16-bit fractional product, truncated or rounded.

Every step clamps to the signed limits of its width instead of wrapping. A sticky flag records that a clamp happened.

An input with `in_valid_i` high gives its result one clock later, with `out_valid_o` high. A new input may arrive on every cycle. The 16-bit results are returned sign-extended to 32 bits.

Top module: `frac_mac_unit`

## Requirements
- R1: Opcode 0 returns the signed 16x16 product shifted left by one. The single exception is operands 0x8000 and 0x8000, whose product is clamped to 0x7FFFFFFF.
- R2: Opcode 1 returns acc + doubled product (as in R1). If two addends of the same sign give a result of the other sign, the result is clamped to 0x7FFFFFFF (positive addends) or 0x80000000 (negative addends).
- R3: Opcode 2 returns acc - doubled product. If the two operands have opposite signs and the result's sign differs from acc's sign, the result is clamped to the limit on acc's side.
- R4: Opcode 7 adds 0x00008000 to acc with 32-bit saturation and returns the upper 16 bits.
- R5: Opcodes 3 and 4 first form the opcode 1 or opcode 2 result. They then round it to 16 bits as in R4.
- R6: Opcode 5 shifts the 32-bit product right by 15 bits, arithmetically. It then clamps the value to the range -32768..32767.
- R7: Opcode 6 adds 0x00004000 to the 32-bit product before that shift. It then clamps the value as in R6.
- R8: A result appears with `out_valid_o` high on the clock edge after its input is accepted. Inputs are accepted on consecutive cycles, and `out_valid_o` is low on the edge after a cycle with no input.
- R9: `ovf_o` becomes 1 after any accepted input that applied a clamp (product, accumulate, round or 16-bit). It holds until a cycle with `clr_ovf_i` high, and a clamp in that same cycle keeps it set.
- R10: After reset, `out_valid_o`, `result_o` and `ovf_o` are all 0.
- R11: The results of opcodes 3 to 7 are 16-bit values, sign-extended into bits 31:16 of `result_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | The operands and opcode on the inputs are valid this cycle |
| op_i | input | 3 | Operation code (0 to 7) |
| a_i | input | 16 | First Q15 operand |
| b_i | input | 16 | Second Q15 operand |
| acc_i | input | 32 | Q31 accumulator value |
| clr_ovf_i | input | 1 | Clears the sticky overflow flag |
| out_valid_o | output | 1 | The result is valid |
| result_o | output | 32 | Result (16-bit results are sign-extended) |
| ovf_o | output | 1 | Sticky saturation flag |

## Verification
The bench drives the most negative operand squared through every opcode. A unit that doubled without clamping would return 0x80000000 there. A unit whose 16-bit paths did not clamp would return -32768 instead of 32767.

Accumulators placed next to both 32-bit limits test the add and subtract overflow tests. A wrapping adder would flip the sign, and a sign test taken from the wrong operand would clamp the wrong cases.

Rounding is driven at 0x7FFF8000 and at negative values. A rounding adder without saturation would return 0x8000, and a logical shift would lose the sign extension.

The overflow flag is checked for holding over idle cycles, for clearing, and for a clear arriving in the same cycle as a clamp. A sequence of back-to-back random operations checks that no result is dropped or appears twice.

// File: rtl/frac_mac_pkg.sv
`timescale 1ns/1ps
package frac_mac_pkg;
  typedef enum logic [2:0] {
    OP_MUL32     = 3'd0,
    OP_MAC       = 3'd1,
    OP_MSU       = 3'd2,
    OP_MAC_RND   = 3'd3,
    OP_MSU_RND   = 3'd4,
    OP_MUL16     = 3'd5,
    OP_MUL16_RND = 3'd6,
    OP_RND       = 3'd7
  } op_e;
endpackage

// File: rtl/frac_mul.sv
`timescale 1ns/1ps
module frac_mul #(
  parameter int DW = 16
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] raw_o,
  output logic [2*DW-1:0] dbl_o,
  output logic            clamp_o
);
  localparam int PW = 2 * DW;
  localparam logic [PW-1:0] CORNER = {2'b01, {(PW-2){1'b0}}};
  localparam logic [PW-1:0] PMAX   = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;
  assign raw     = $signed(a_i) * $signed(b_i);
  assign raw_o   = raw;
  // only min*min can overflow the doubling
  assign clamp_o = (raw == CORNER);
  assign dbl_o   = clamp_o ? PMAX : {raw[PW-2:0], 1'b0};
endmodule

// File: rtl/sat_addsub.sv
`timescale 1ns/1ps
module sat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         clamp_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] sum;
  logic         sgn_rel;

  assign sum     = sub_i ? (x_i - y_i) : (x_i + y_i);
  assign sgn_rel = sub_i ? (x_i[W-1] ^ y_i[W-1]) : ~(x_i[W-1] ^ y_i[W-1]);
  assign clamp_o = sgn_rel & (sum[W-1] ^ x_i[W-1]);
  assign sum_o   = clamp_o ? (x_i[W-1] ? SMIN : SMAX) : sum;
endmodule

// File: rtl/sat_narrow.sv
`timescale 1ns/1ps
module sat_narrow #(
  parameter int IW = 32,
  parameter int OW = 16
) (
  input  logic [IW-1:0] in_i,
  output logic [OW-1:0] out_o,
  output logic          clamp_o
);
  logic [IW-OW:0] top;
  assign top     = in_i[IW-1:OW-1];
  assign clamp_o = ~(&top) & (|top);
  assign out_o   = clamp_o ? (in_i[IW-1] ? {1'b1, {(OW-1){1'b0}}} : {1'b0, {(OW-1){1'b1}}})
                           : in_i[OW-1:0];
endmodule

// File: rtl/frac_mac_unit.sv
`timescale 1ns/1ps
module frac_mac_unit
  import frac_mac_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [2:0]        op_i,
  input  logic [DW-1:0]     a_i,
  input  logic [DW-1:0]     b_i,
  input  logic [2*DW-1:0]   acc_i,
  input  logic              clr_ovf_i,
  output logic              out_valid_o,
  output logic [2*DW-1:0]   result_o,
  output logic              ovf_o
);
  localparam int AW = 2 * DW;
  localparam logic [AW-1:0] RND_HALF = AW'(1) << (DW - 1);
  localparam logic [AW-1:0] MUL_HALF = AW'(1) << (DW - 2);

  op_e op;
  assign op = op_e'(op_i);

  logic [AW-1:0] raw, dbl, acc_sum, rnd_in, rnd_sum, sh_in, sh;
  logic [DW-1:0] n16;
  logic          p_clamp, a_clamp, r_clamp, n_clamp, acc_sub;

  frac_mul #(.DW(DW)) i_mul (
    .a_i(a_i), .b_i(b_i), .raw_o(raw), .dbl_o(dbl), .clamp_o(p_clamp)
  );

  assign acc_sub = (op == OP_MSU) || (op == OP_MSU_RND);

  sat_addsub #(.W(AW)) i_acc (
    .x_i(acc_i), .y_i(dbl), .sub_i(acc_sub), .sum_o(acc_sum), .clamp_o(a_clamp)
  );

  assign rnd_in = (op == OP_RND) ? acc_i : acc_sum;

  sat_addsub #(.W(AW)) i_rnd (
    .x_i(rnd_in), .y_i(RND_HALF), .sub_i(1'b0), .sum_o(rnd_sum), .clamp_o(r_clamp)
  );

  assign sh_in = (op == OP_MUL16_RND) ? raw + MUL_HALF : raw;
  assign sh    = AW'($signed(sh_in) >>> (DW - 1));

  sat_narrow #(.IW(AW), .OW(DW)) i_nar (
    .in_i(sh), .out_o(n16), .clamp_o(n_clamp)
  );

  logic [AW-1:0] res_d;
  logic          sat_d;

  always_comb begin
    unique case (op)
      OP_MUL32: begin
        res_d = dbl;
        sat_d = p_clamp;
      end
      OP_MAC, OP_MSU: begin
        res_d = acc_sum;
        sat_d = p_clamp | a_clamp;
      end
      OP_MAC_RND, OP_MSU_RND: begin
        res_d = {{DW{rnd_sum[AW-1]}}, rnd_sum[AW-1:DW]};
        sat_d = p_clamp | a_clamp | r_clamp;
      end
      OP_MUL16, OP_MUL16_RND: begin
        res_d = {{DW{n16[DW-1]}}, n16};
        sat_d = n_clamp;
      end
      default: begin
        res_d = {{DW{rnd_sum[AW-1]}}, rnd_sum[AW-1:DW]};
        sat_d = r_clamp;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      result_o    <= '0;
      ovf_o       <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      if (in_valid_i) result_o <= res_d;
      // a clamp in the same cycle beats a clear
      if (in_valid_i && sat_d) ovf_o <= 1'b1;
      else if (clr_ovf_i)      ovf_o <= 1'b0;
    end
  end

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_no_spurious_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o && !clr_ovf_i |=> ovf_o);
  p_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ovf_i && !in_valid_i |=> !ovf_o);
  p_sext_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && op_i >= 3'd3 |=> (result_o[AW-1:DW-1] == '0) || (&result_o[AW-1:DW-1]));
  p_corner_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && op_i == 3'd0 && a_i == {1'b1, {(DW-1){1'b0}}} && b_i == {1'b1, {(DW-1){1'b0}}}
    |=> result_o == {1'b0, {(AW-1){1'b1}}} && ovf_o);
endmodule

// File: tb/test_frac_mac_unit.sv
`timescale 1ns/1ps
module test_frac_mac_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, clr = 1'b0;
  logic [2:0]  op = '0;
  logic [15:0] a = '0, b = '0;
  logic [31:0] acc = '0;
  logic        out_valid, ovf;
  logic [31:0] result;

  frac_mac_unit i_frac_mac_unit (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .op_i(op), .a_i(a), .b_i(b),
    .acc_i(acc), .clr_ovf_i(clr), .out_valid_o(out_valid), .result_o(result), .ovf_o(ovf)
  );

  typedef struct { logic [31:0] res; logic ovf; string tag; } exp_t;
  exp_t q[$];
  int   checks = 0, errors = 0;
  bit   m_ovf = 1'b0, done = 1'b0;

  localparam longint MX32 = 64'sd2147483647;
  localparam longint MN32 = -64'sd2147483648;
  localparam longint MX16 = 64'sd32767;
  localparam longint MN16 = -64'sd32768;

  function automatic longint clamp(longint v, longint lo, longint hi, inout bit f);
    if (v > hi) begin f = 1'b1; return hi; end
    if (v < lo) begin f = 1'b1; return lo; end
    return v;
  endfunction

  function automatic logic [31:0] model(logic [2:0] o, logic [15:0] x, logic [15:0] y,
                                        logic [31:0] ac, inout bit f);
    longint p, d, s, r, av;
    bit fp = 1'b0;
    p  = longint'($signed(x)) * longint'($signed(y));
    d  = clamp(2 * p, MN32, MX32, fp);
    av = longint'($signed(ac));
    case (o)
      3'd0: begin r = d; f |= fp; end
      3'd1: begin r = clamp(av + d, MN32, MX32, f); f |= fp; end
      3'd2: begin r = clamp(av - d, MN32, MX32, f); f |= fp; end
      3'd3: begin s = clamp(av + d, MN32, MX32, f); r = clamp(s + 32768, MN32, MX32, f) >>> 16; f |= fp; end
      3'd4: begin s = clamp(av - d, MN32, MX32, f); r = clamp(s + 32768, MN32, MX32, f) >>> 16; f |= fp; end
      3'd5: r = clamp(p >>> 15, MN16, MX16, f);
      3'd6: r = clamp((p + 16384) >>> 15, MN16, MX16, f);
      default: r = clamp(av + 32768, MN32, MX32, f) >>> 16;
    endcase
    return r[31:0];
  endfunction

  task automatic drive(logic [2:0] o, logic [15:0] x, logic [15:0] y, logic [31:0] ac,
                       bit c, string tag);
    bit f = 1'b0;
    exp_t e;
    e.res = model(o, x, y, ac, f);
    m_ovf = f | (m_ovf & ~c);
    e.ovf = m_ovf;
    e.tag = tag;
    q.push_back(e);
    in_valid = 1'b1; op = o; a = x; b = y; acc = ac; clr = c;
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic idle(bit c);
    m_ovf = m_ovf & ~c;
    clr = c;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R8 spurious valid", result, 32'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(result == e.res, e.tag, result, e.res);
        check(ovf == e.ovf, "R9 ovf flag", {31'h0, ovf}, {31'h0, e.ovf});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(out_valid == 1'b0, "R10 valid in reset", {31'h0, out_valid}, 32'h0);
    check(result == 32'h0, "R10 result in reset", result, 32'h0);
    check(ovf == 1'b0, "R10 ovf in reset", {31'h0, ovf}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1
    drive(3'd0, 16'h4000, 16'h4000, 32'h0, 1'b0, "R1 mult32");
    drive(3'd0, 16'h8000, 16'h7fff, 32'h0, 1'b0, "R1 mult32 neg");
    drive(3'd0, 16'h8000, 16'h8000, 32'h0, 1'b0, "R1 mult32 corner");
    // R9: hold over idle, clear, set wins
    idle(1'b0); idle(1'b0);
    drive(3'd0, 16'h0001, 16'h0001, 32'h0, 1'b0, "R9 held");
    drive(3'd0, 16'h0002, 16'h0003, 32'h0, 1'b1, "R9 cleared");
    drive(3'd0, 16'h8000, 16'h8000, 32'h0, 1'b1, "R9 set wins");
    idle(1'b1);
    drive(3'd5, 16'h1234, 16'h0100, 32'h0, 1'b0, "R9 after idle clear");
    // R2
    drive(3'd1, 16'h1000, 16'h2000, 32'h00001000, 1'b0, "R2 mac");
    drive(3'd1, 16'h7fff, 16'h7fff, 32'h7fffff00, 1'b1, "R2 mac pos clamp");
    drive(3'd1, 16'h8000, 16'h7fff, 32'h80000100, 1'b1, "R2 mac neg clamp");
    drive(3'd1, 16'h8000, 16'h8000, 32'hc0000000, 1'b1, "R2 mac corner");
    // R3
    drive(3'd2, 16'h0100, 16'h0200, 32'h00100000, 1'b1, "R3 msu");
    drive(3'd2, 16'h7fff, 16'h7fff, 32'h80000100, 1'b1, "R3 msu neg clamp");
    drive(3'd2, 16'h8000, 16'h7fff, 32'h7fffff00, 1'b1, "R3 msu pos clamp");
    // R4 / R11
    drive(3'd7, 16'h0, 16'h0, 32'h12348000, 1'b1, "R4 round");
    drive(3'd7, 16'h0, 16'h0, 32'h7fff8000, 1'b1, "R4 round sat");
    drive(3'd7, 16'h0, 16'h0, 32'hffffffff, 1'b1, "R4 round neg");
    drive(3'd7, 16'h0, 16'h0, 32'h80000000, 1'b1, "R11 round sext");
    // R5
    drive(3'd3, 16'h4000, 16'h4000, 32'h00008000, 1'b1, "R5 mac_round");
    drive(3'd4, 16'h4000, 16'h4000, 32'h00000000, 1'b1, "R5 msu_round");
    drive(3'd3, 16'h7fff, 16'h7fff, 32'h7fff0000, 1'b1, "R5 mac_round sat");
    // R6
    drive(3'd5, 16'h4000, 16'h4000, 32'h0, 1'b1, "R6 mult16");
    drive(3'd5, 16'hffff, 16'h0001, 32'h0, 1'b1, "R6 mult16 neg");
    drive(3'd5, 16'h8000, 16'h8000, 32'h0, 1'b1, "R6 mult16 sat");
    // R7
    drive(3'd6, 16'h0001, 16'h0001, 32'h0, 1'b1, "R7 mult16r small");
    drive(3'd6, 16'h00c0, 16'h0080, 32'h0, 1'b1, "R7 mult16r up");
    drive(3'd6, 16'h8000, 16'h8000, 32'h0, 1'b1, "R7 mult16r sat");
    drive(3'd6, 16'hff40, 16'h0080, 32'h0, 1'b1, "R7 mult16r neg");
    // R8 back-to-back random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0] ro;
      ro = 3'($urandom_range(0, 7));
      drive(ro, 16'($urandom), 16'($urandom), $urandom, 1'($urandom_range(0, 1)), "R8 back-to-back");
    end
    idle(1'b0); idle(1'b0);
    check(q.size() == 0, "R8 results outstanding", 32'(q.size()), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule